// File: doc/BRIEF.md
# Serial-Bus Register Slave for an LED Blinker

This block is the two-wire serial (I2C-compatible) slave front end of an eight-channel LED blinker. It exposes a bank of seven 8-bit registers. Slot 0 reads the eight pad levels. Slots 1 to 6 hold two blink prescalers, two duty values and two LED selector bytes. These six writable registers drive output ports that feed the blink generators elsewhere on the chip.

A bus master addresses the slave with a 7-bit address. The upper four bits of that address are fixed by a parameter, and the lower three come from strap pins, so eight copies can share one bus. After the address, the first byte written goes into an internal control register. Its three low bits select a register, and bit 4 turns on auto-increment. Every byte after that is either written to the selected register or, after a repeated START with the read address, read from it. With auto-increment on, the pointer steps after each data byte and wraps from the last register back to slot 0, so one transaction can program the whole bank.

SCL and SDA are oversampled by the block's system clock through two-flop synchronisers. START and STOP are detected on the synchronised levels. The block only ever pulls SDA low and never drives it high.

Top module: `blinkRegSlave`

## Requirements
- R1: An address byte is acknowledged only when its upper seven bits equal {DEV_BASE (default 4'b1100), devPins}. On a mismatch the slave stays silent and ignores the rest of the transaction until the next START.
- R2: The first byte after a write address loads the control register: bits 2:0 are the register pointer and bit 4 is the auto-increment flag. The byte is acknowledged when the pointer is 0 to 6.
- R3: A control byte whose pointer field is 7 is not acknowledged and leaves the previous pointer and flag unchanged.
- R4: Each data byte written is acknowledged and stored in the register selected by the pointer. Pointer 1 maps to rate0, 2 to duty0, 3 to rate1, 4 to duty1, 5 to ledSel0 and 6 to ledSel1.
- R5: With the flag set, the pointer advances by one after each data byte written or read, and wraps from 6 to 0.
- R6: With the flag clear, the pointer stays put, so repeated writes overwrite one register and repeated reads return the same register.
- R7: A write to slot 0 is acknowledged but changes no register. A read of slot 0 returns padIn as sampled when that byte is loaded, which is at the SCL fall that ends the preceding acknowledge.
- R8: After a read address, bytes are sent MSB first. SDA is released in every master-acknowledge slot. A master NACK ends the read and leaves SDA released.
- R9: While rstN is low, rate0, duty0, rate1 and duty1 are 00h, ledSel0 and ledSel1 are 55h, the pointer and flag are 0, and SDA is released.
- R10: A STOP returns the slave to idle. Bytes clocked in after it without a START are neither acknowledged nor stored.
- R11: sdaPullDown changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock level |
| sdaIn | input | 1 | Bus data level as seen on the wire |
| devPins | input | 3 | Strap pins giving the low address bits |
| padIn | input | 8 | Pad levels returned by register slot 0 |
| sdaPullDown | output | 1 | High pulls SDA low (open-drain) |
| rate0 | output | 8 | Prescaler of blink source 0 (slot 1) |
| duty0 | output | 8 | Duty value of blink source 0 (slot 2) |
| rate1 | output | 8 | Prescaler of blink source 1 (slot 3) |
| duty1 | output | 8 | Duty value of blink source 1 (slot 4) |
| ledSel0 | output | 8 | Selector byte for LEDs 0 to 3 (slot 5) |
| ledSel1 | output | 8 | Selector byte for LEDs 4 to 7 (slot 6) |

## Verification
Several properties are checked on every cycle:
- SDA only changes while SCL is low.
- The register outputs change only in the cycle after a write strobe.
- An acknowledge follows every accepted control byte and every data write.
- At most one strobe is active at a time.
- The register outputs sit at their defaults during reset.

Only the bench's scenarios can show the rest: which address the slave accepts, the pointer walk and its wrap from 6 to 0, the rejection of pointer 7, the timing of the pad snapshot, and silence after a mismatch or a STOP. The bench sweeps all 64 pairs of strap setting and address, and runs bursts longer than the bank.

// File: rtl/blinkRegPkg.sv
package blinkRegPkg;
  localparam int DATA_W    = 8;
  localparam int REG_COUNT = 7;
  localparam int PTR_W     = $clog2(REG_COUNT + 1);
  localparam int AI_BIT    = 4;
  localparam int SEL_FIRST = 5;
  localparam logic [DATA_W-1:0] SEL_RESET = 8'h55;

  typedef struct packed {
    logic              loadCtrl;
    logic              writeReg;
    logic              loadTx;
    logic              shiftTx;
    logic [DATA_W-1:0] rxByte;
  } strobe_t;

  typedef enum logic [2:0] {PH_IDLE, PH_RX, PH_RACK, PH_TX, PH_TACK} phase_e;
  typedef enum logic [1:0] {KD_ADDR, KD_CTRL, KD_DATA} kind_e;
endpackage

// File: rtl/blinkRegCtrl.sv
module blinkRegCtrl
  import blinkRegPkg::*;
#(
  parameter logic [3:0] DEV_BASE = 4'b1100
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  input  logic [2:0] devPins,
  input  logic    txBit,
  output strobe_t stb,
  output logic    sdaPullDown
);
  localparam logic [PTR_W-1:0] BAD_PTR = PTR_W'(REG_COUNT);

  logic [1:0] sclSync, sdaSync;
  logic sclD, sdaD, sclS, sdaS;
  logic startEv, stopEv, sclRise, sclFall;

  phase_e phase;
  kind_e  kind;
  logic [2:0] bitCnt;
  logic [DATA_W-1:0] rxQ;
  logic gotByte, readMode, ackDrive, masterAck;
  logic byteEnd, addrHit, ptrOk, ackNow, ackEnd, goTx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclD    <= sclSync[1];
      sdaD    <= sdaSync[1];
    end
  end

  assign sclS    = sclSync[1];
  assign sdaS    = sdaSync[1];
  assign startEv = sclS & sclD & sdaD & ~sdaS;
  assign stopEv  = sclS & sclD & ~sdaD & sdaS;
  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;

  always_comb begin
    byteEnd = (phase == PH_RX) && sclFall && gotByte;
    addrHit = rxQ[DATA_W-1:1] == {DEV_BASE, devPins};
    ptrOk   = rxQ[PTR_W-1:0] != BAD_PTR;
    unique case (kind)
      KD_ADDR: ackNow = addrHit;
      KD_CTRL: ackNow = ptrOk;
      default: ackNow = 1'b1;
    endcase
    ackEnd = (phase == PH_RACK) && sclFall;
    goTx   = ackEnd && (kind == KD_ADDR) && readMode;
    stb.loadCtrl = byteEnd && (kind == KD_CTRL) && ptrOk;
    stb.writeReg = byteEnd && (kind == KD_DATA);
    stb.loadTx   = goTx || ((phase == PH_TACK) && sclFall && masterAck);
    stb.shiftTx  = (phase == PH_TX) && sclFall && (bitCnt != 3'd7);
    stb.rxByte   = rxQ;
  end

  assign sdaPullDown = ackDrive | ((phase == PH_TX) & ~txBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      kind      <= KD_ADDR;
      bitCnt    <= '0;
      rxQ       <= '0;
      gotByte   <= 1'b0;
      readMode  <= 1'b0;
      ackDrive  <= 1'b0;
      masterAck <= 1'b0;
    end else if (startEv) begin
      phase    <= PH_RX;
      kind     <= KD_ADDR;
      bitCnt   <= '0;
      gotByte  <= 1'b0;
      ackDrive <= 1'b0;
    end else if (stopEv) begin
      phase    <= PH_IDLE;
      ackDrive <= 1'b0;
    end else begin
      unique case (phase)
        PH_RX: begin
          if (sclRise && !gotByte) begin
            rxQ <= {rxQ[DATA_W-2:0], sdaS};
            if (bitCnt == 3'd7) gotByte <= 1'b1;
            else                bitCnt  <= bitCnt + 3'd1;
          end else if (byteEnd) begin
            if (kind == KD_ADDR) readMode <= rxQ[0];
            if (ackNow) begin
              phase    <= PH_RACK;
              ackDrive <= 1'b1;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        PH_RACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            bitCnt   <= '0;
            if (goTx) begin
              phase <= PH_TX;
            end else begin
              phase   <= PH_RX;
              gotByte <= 1'b0;
              kind    <= (kind == KD_ADDR) ? KD_CTRL : KD_DATA;
            end
          end
        end
        PH_TX: begin
          if (sclFall) begin
            if (bitCnt == 3'd7) phase  <= PH_TACK;
            else                bitCnt <= bitCnt + 3'd1;
          end
        end
        PH_TACK: begin
          if (sclRise) masterAck <= ~sdaS;
          if (sclFall) begin
            bitCnt <= '0;
            phase  <= masterAck ? PH_TX : PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blinkRegData.sv
module blinkRegData
  import blinkRegPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  input  logic [DATA_W-1:0] padIn,
  output logic    txBit,
  output logic [REG_COUNT-1:1][DATA_W-1:0] regQ
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(REG_COUNT - 1);

  logic [PTR_W-1:0]  ptrQ, ptrNext;
  logic              autoInc;
  logic [DATA_W-1:0] txQ, readVal;
  logic [DATA_W-1:0] regArr [1:REG_COUNT-1];

  assign ptrNext = (ptrQ >= LAST_PTR) ? '0 : ptrQ + PTR_W'(1);

  always_comb begin
    readVal = padIn;
    for (int i = 1; i < REG_COUNT; i++)
      if (ptrQ == PTR_W'(i)) readVal = regArr[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ    <= '0;
      autoInc <= 1'b0;
    end else if (stb.loadCtrl) begin
      ptrQ    <= stb.rxByte[PTR_W-1:0];
      autoInc <= stb.rxByte[AI_BIT];
    end else if ((stb.writeReg || stb.loadTx) && autoInc) begin
      ptrQ <= ptrNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            txQ <= '0;
    else if (stb.loadTx)  txQ <= readVal;
    else if (stb.shiftTx) txQ <= {txQ[DATA_W-2:0], 1'b0};
  end

  assign txBit = txQ[DATA_W-1];

  for (genvar g = 1; g < REG_COUNT; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL = (g >= SEL_FIRST) ? SEL_RESET : '0;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regArr[g] <= RST_VAL;
      else if (stb.writeReg && ptrQ == PTR_W'(g)) regArr[g] <= stb.rxByte;
    end
    assign regQ[g] = regArr[g];
  end
endmodule

// File: rtl/blinkRegSlave.sv
module blinkRegSlave
  import blinkRegPkg::*;
#(
  parameter logic [3:0] DEV_BASE = 4'b1100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] devPins,
  input  logic [7:0] padIn,
  output logic       sdaPullDown,
  output logic [7:0] rate0,
  output logic [7:0] duty0,
  output logic [7:0] rate1,
  output logic [7:0] duty1,
  output logic [7:0] ledSel0,
  output logic [7:0] ledSel1
);
  strobe_t ctrlStrobe;
  logic    txBit;
  logic [REG_COUNT-1:1][DATA_W-1:0] regQ;

  blinkRegCtrl #(.DEV_BASE(DEV_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .devPins(devPins),
    .txBit(txBit), .stb(ctrlStrobe), .sdaPullDown(sdaPullDown)
  );

  blinkRegData u_data (
    .clk(clk), .rstN(rstN), .stb(ctrlStrobe), .padIn(padIn),
    .txBit(txBit), .regQ(regQ)
  );

  assign rate0   = regQ[1];
  assign duty0   = regQ[2];
  assign rate1   = regQ[3];
  assign duty1   = regQ[4];
  assign ledSel0 = regQ[5];
  assign ledSel1 = regQ[6];
endmodule

// File: rtl/blinkRegChk.sv
module blinkRegChk
  import blinkRegPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        sclIn,
  input logic        sdaPullDown,
  input logic [47:0] regBus,
  input strobe_t     stb
);
  p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullDown) |-> (!$past(sclIn, 2) && !$past(sclIn, 3)))
    else $error("sdaPullDown moved while SCL was high");

  p_regs_on_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regBus) |-> $past(stb.writeReg))
    else $error("register output moved without a write strobe");

  p_write_acked_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeReg |=> sdaPullDown)
    else $error("data write not acknowledged");

  p_ctrl_acked_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadCtrl |=> sdaPullDown)
    else $error("control byte loaded without acknowledge");

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadCtrl, stb.writeReg, stb.loadTx, stb.shiftTx}))
    else $error("overlapping strobes");

  always @(posedge clk) begin
    if (!rstN) begin
      p_defaults_r9: assert (regBus == {32'h0, 16'h5555} && !sdaPullDown)
        else $error("reset values wrong");
    end
  end
endmodule

bind blinkRegSlave blinkRegChk u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullDown(sdaPullDown),
  .regBus({rate0, duty0, rate1, duty1, ledSel0, ledSel1}), .stb(ctrlStrobe)
);

// File: tb/test_blinkRegSlave.sv
`timescale 1ns/1ps
module test_blinkRegSlave;
  localparam int Q = 8;
  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [2:0] devPins = 3'd0;
  logic [7:0] padIn = 8'h00;
  logic sdaPullDown;
  logic [7:0] rate0, duty0, rate1, duty1, ledSel0, ledSel1;
  wire  sdaLine = sdaM & ~sdaPullDown;

  int checks = 0, failures = 0, r11Bad = 0;
  logic done = 1'b0;
  logic [7:0] model [0:6];
  logic prevPd = 1'b0;

  always #10 clk = ~clk;

  blinkRegSlave i_blinkRegSlave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .devPins(devPins),
    .padIn(padIn), .sdaPullDown(sdaPullDown), .rate0(rate0), .duty0(duty0),
    .rate1(rate1), .duty1(duty1), .ledSel0(ledSel0), .ledSel1(ledSel1)
  );

  // R11 monitor: pull-down must not move while SCL is high
  always begin
    @(posedge clk); #2;
    if (rstN && sdaPullDown !== prevPd && sclM) r11Bad++;
    prevPd = sdaPullDown;
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic checkRegs(input string tag);
    check({tag, " rate0"},   rate0,   model[1]);
    check({tag, " duty0"},   duty0,   model[2]);
    check({tag, " rate1"},   rate1,   model[3]);
    check({tag, " duty1"},   duty1,   model[4]);
    check({tag, " ledSel0"}, ledSel0, model[5]);
    check({tag, " ledSel1"}, ledSel1, model[6]);
  endtask

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(1); sclM = 1'b1; waitQ(1);
    sdaM = 1'b0; waitQ(1); sclM = 1'b0; waitQ(1);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(1); sclM = 1'b1; waitQ(1); sdaM = 1'b1; waitQ(1);
  endtask

  task automatic clockBit(input logic b, output logic seen);
    sdaM = b; waitQ(1); sclM = 1'b1; waitQ(1);
    seen = sdaLine; waitQ(1); sclM = 1'b0; waitQ(1);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic readByte(output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      b[i] = s;
    end
  endtask

  task automatic masterAckBit(input logic ack);
    logic s;
    clockBit(~ack, s);
  endtask

  localparam logic [6:0] ADR = {4'b1100, 3'b101};

  initial begin
    logic ack;
    logic [7:0] rd;
    logic [7:0] expPad;
    model[0] = 8'h00; model[1] = 8'h00; model[2] = 8'h00; model[3] = 8'h00;
    model[4] = 8'h00; model[5] = 8'h55; model[6] = 8'h55;
    #1 rstN = 1'b0;
    repeat (5) @(negedge clk);
    checkRegs("R9 reset");
    check("R9 sda released in reset", {7'd0, sdaPullDown}, 8'h00);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1: sweep strap pins against every low address value
    for (int p = 0; p < 8; p++) begin
      for (int a = 0; a < 8; a++) begin
        devPins = 3'(p);
        busStart();
        writeByte({4'b1100, 3'(a), 1'b0}, ack);
        busStop();
        check($sformatf("R1 pins=%0d addr=%0d", p, a), {7'd0, ack}, {7'd0, p == a});
      end
    end
    devPins = 3'b101;
    busStart();
    writeByte({4'b1101, 3'b101, 1'b0}, ack);
    check("R1 upper bits mismatch", {7'd0, ack}, 8'h00);
    writeByte(8'h11, ack);
    check("R1 silent after mismatch (ctrl)", {7'd0, ack}, 8'h00);
    writeByte(8'hAA, ack);
    check("R1 silent after mismatch (data)", {7'd0, ack}, 8'h00);
    busStop();
    checkRegs("R1 no store after mismatch");

    // R2 R4 R5 R7: burst write from slot 1 with auto-increment, wrap to 0
    busStart();
    writeByte({ADR, 1'b0}, ack);
    check("R1 own address write", {7'd0, ack}, 8'h01);
    writeByte(8'h11, ack);
    check("R2 ctrl ptr1 ai acked", {7'd0, ack}, 8'h01);
    for (int k = 1; k <= 6; k++) begin
      writeByte(8'(8'h20 + 8'(k * 7)), ack);
      model[k] = 8'(8'h20 + 8'(k * 7));
      check($sformatf("R4 data byte %0d acked", k), {7'd0, ack}, 8'h01);
    end
    writeByte(8'hEE, ack);
    check("R7 slot0 write acked", {7'd0, ack}, 8'h01);
    writeByte(8'h9C, ack);
    model[1] = 8'h9C;
    check("R5 wrapped write acked", {7'd0, ack}, 8'h01);
    busStop();
    checkRegs("R5 burst wrap");

    // R6: no auto-increment, repeated writes to slot 3
    busStart();
    writeByte({ADR, 1'b0}, ack);
    writeByte(8'h03, ack);
    writeByte(8'h3C, ack);
    writeByte(8'hC3, ack);
    writeByte(8'h5A, ack);
    model[3] = 8'h5A;
    busStop();
    checkRegs("R6 fixed pointer write");

    // R3: pointer 7 rejected, old pointer kept
    busStart();
    writeByte({ADR, 1'b0}, ack);
    writeByte(8'h17, ack);
    check("R3 ctrl ptr7 nacked", {7'd0, ack}, 8'h00);
    busStop();
    busStart();
    writeByte({ADR, 1'b1}, ack);
    check("R8 read address acked", {7'd0, ack}, 8'h01);
    readByte(rd);
    check("R3 pointer kept at 3", rd, model[3]);
    masterAckBit(1'b1);
    readByte(rd);
    check("R6 repeated read same slot", rd, model[3]);
    masterAckBit(1'b0);
    waitQ(1);
    check("R8 released after nack", {7'd0, sdaPullDown}, 8'h00);
    busStop();

    // R7 R8 R5: auto-increment read from slot 0 across the wrap
    busStart();
    writeByte({ADR, 1'b0}, ack);
    writeByte(8'h10, ack);
    padIn = 8'hA5;
    expPad = 8'hA5;
    busStart();
    writeByte({ADR, 1'b1}, ack);
    padIn = ~expPad;
    for (int k = 0; k < 8; k++) begin
      readByte(rd);
      if (k % 7 == 0) check($sformatf("R7 slot0 read byte %0d", k), rd, expPad);
      else            check($sformatf("R5 read byte %0d", k), rd, model[k % 7]);
      expPad = 8'(8'h30 + 8'(k));
      padIn  = expPad;
      masterAckBit(k < 7);
      padIn  = ~expPad;
    end
    waitQ(1);
    check("R8 released after final nack", {7'd0, sdaPullDown}, 8'h00);
    busStop();
    checkRegs("R7 slot0 write ignored");

    // R10: bytes after STOP without START are ignored
    writeByte({ADR, 1'b0}, ack);
    check("R10 no ack after stop", {7'd0, ack}, 8'h00);
    writeByte(8'h01, ack);
    writeByte(8'hFF, ack);
    check("R10 no ack for data after stop", {7'd0, ack}, 8'h00);
    checkRegs("R10 regs unchanged");

    // R9: reset in the middle of operation
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    model[1] = 8'h00; model[2] = 8'h00; model[3] = 8'h00;
    model[4] = 8'h00; model[5] = 8'h55; model[6] = 8'h55;
    checkRegs("R9 mid reset");
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    check("R11 pull-down moved with SCL high", 8'(r11Bad), 8'h00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule